// File: doc/BRIEF.md
# Clock-Enable Divider Tree

This block turns one fast reference clock into a family of single-cycle enable pulses, one per clock domain. Logic in each domain runs on the fast clock and advances only in cycles where its enable is high. A chain of counters sets the rate of each enable. The main source is either a free-running PLL stand-in or an externally supplied reference tick. An optional stage drops one pulse out of every four, which gives a three-quarter rate for the CPU domain. A programmable divider then produces the CPU enable. A second programmable divider, cascaded from the CPU enable, produces the bus enable. A fixed halving of the bus enable produces the peripheral enable. A second PLL stand-in has its own enable output, which a control bit can shut off.

All of these choices come from one 32-bit control word. Software reaches it through a word-aligned write and read port. Any write to the control word restarts every divider from zero, so a new ratio always begins on a clean pulse boundary. At reset the word selects CPU, bus and peripheral rates in the ratio 4:2:1.

Top module: `clk_enable_tree`

## Requirements
- R1: After reset the control word reads 0xD000_0000: CPU divide field 3, bus divide field 1, all other control bits clear. The CPU, bus and peripheral enables then pulse at 1/4, 1/8 and 1/16 of the main source rate.
- R2: With bit 22 (bypass) clear, the main enable pulses every MAIN_PERIOD clock cycles (every cycle by default). With bit 22 set, the main enable equals the ref_tick input.
- R3: With bit 23 (second-source off) set, aux_en never pulses. With it clear, aux_en pulses once every AUX_PERIOD cycles (2 by default).
- R4: With bit 14 (three-quarter select) set, the 4th, 8th, 12th and later main pulses after a control write are withheld from the CPU divider. With the bit clear, every main pulse is passed on.
- R5: The CPU enable counts (main pulses passed on) / (1 + bits 31:30), starting from a zeroed counter.
- R6: The bus enable counts CPU pulses / (1 + bits 29:28).
- R7: The peripheral enable counts exactly half of the bus pulses.
- R8: Every peripheral pulse coincides with a bus pulse. Every bus pulse coincides with a CPU pulse. Every CPU pulse coincides with a main pulse.
- R9: The control word lives at byte offset 0x008. A write there with bus_wr is stored, and a read there returns it. Any other address reads zero and leaves the word unchanged when written. This covers other aligned words below 0x070, offsets at or above 0x070, and unaligned addresses.
- R10: A control write zeroes every divider and the quarter-drop phase. The first CPU pulse after the write therefore comes on the (N+1)-th passed main pulse, where N is the new CPU divide field. The count before the write has no effect on this.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_tick | input | 1 | Raw reference tick, used as the main source in bypass |
| bus_wr | input | 1 | Write strobe for the control port |
| bus_addr | input | ADDR_W (12) | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| main_en | output | 1 | Main source enable |
| aux_en | output | 1 | Second source enable |
| cpu_en | output | 1 | CPU domain enable |
| bus_en | output | 1 | Bus domain enable |
| periph_en | output | 1 | Peripheral domain enable |

## Verification
The bench builds the block with its default parameters: a main stand-in that pulses every cycle, a second stand-in that pulses every other cycle, 2-bit divide fields and a 12-bit address. With these values all 64 combinations of CPU divide, bus divide, three-quarter select and bypass can be swept, each over a 960-cycle window. In bypass the reference tick runs at one cycle in three, so the swallower sees a sparse, uneven pulse train as well as a dense one. Expected counts are computed from the window length, and the first-pulse position after a repeated write isolates the reload behaviour.

// File: rtl/cet_pkg.sv
// Package: field positions and decoded form of the clock control word.
// Assumes a 32-bit control word; field positions are fixed by software.
package cet_pkg;
    localparam int WORD_W      = 32;
    localparam int DIV_W       = 2;
    localparam int CPU_DIV_LSB = 30;
    localparam int BUS_DIV_LSB = 28;
    localparam int BYPASS_BIT  = 22;
    localparam int AUX_OFF_BIT = 23;
    localparam int QUARTER_BIT = 14;
    localparam logic [WORD_W-1:0] CTRL_RESET = 32'hD000_0000;

    typedef struct packed {
        logic             bypass;
        logic             aux_off;
        logic             three_q;
        logic [DIV_W-1:0] cpu_div;
        logic [DIV_W-1:0] bus_div;
    } cfg_t;

    // Pull the control fields out of a raw word.
    function automatic cfg_t decode(input logic [WORD_W-1:0] w);
        cfg_t c;
        c.bypass  = w[BYPASS_BIT];
        c.aux_off = w[AUX_OFF_BIT];
        c.three_q = w[QUARTER_BIT];
        c.cpu_div = w[CPU_DIV_LSB +: DIV_W];
        c.bus_div = w[BUS_DIV_LSB +: DIV_W];
        return c;
    endfunction
endpackage

// File: rtl/cet_ctrl_reg.sv
// Control register with a word-aligned write/read port.
// Only the exact aligned offset CTRL_OFFSET inside the window hits; all else
// reads zero and ignores writes. Raises reload for the cycle of a hit write.
module cet_ctrl_reg
    import cet_pkg::*;
#(
    parameter int                ADDR_W      = 12,
    parameter logic [ADDR_W-1:0] CTRL_OFFSET = 12'h008,
    parameter logic [ADDR_W-1:0] WINDOW_END  = 12'h070
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output cfg_t              cfg,
    output logic              reload
);
    logic [WORD_W-1:0] word_q;
    logic              hit;

    // Address decode: aligned, inside the window, and on the control word.
    always_comb begin
        hit = (bus_addr[1:0] == 2'b00) && (bus_addr < WINDOW_END) &&
              (bus_addr == CTRL_OFFSET);
    end

    // Register storage: reset value, else capture a hitting write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            word_q <= CTRL_RESET;
        else if (bus_wr && hit)
            word_q <= bus_wdata;
    end

    assign bus_rdata = hit ? word_q : '0;
    assign cfg       = decode(word_q);
    assign reload    = bus_wr && hit;

    assert_reset_word_R1: assert property (@(posedge clk)
        !rst_n |=> (word_q == CTRL_RESET));
    assert_miss_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && (bus_addr == CTRL_OFFSET)) |=> $stable(word_q));
endmodule

// File: rtl/cet_pulse_src.sv
// Free-running stand-in for a PLL: one-cycle pulse every PERIOD clocks.
// PERIOD of 1 yields a pulse every cycle with no counter.
module cet_pulse_src #(
    parameter int PERIOD = 1
) (
    input  logic clk,
    input  logic rst_n,
    output logic pulse
);
    localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;

    generate
        if (PERIOD == 1) begin : g_every
            assign pulse = 1'b1;
        end else begin : g_count
            logic [CW-1:0] cnt;
            // Period counter wrapping at PERIOD-1.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    cnt <= '0;
                else
                    cnt <= (cnt == CW'(PERIOD - 1)) ? '0 : cnt + 1'b1;
            end
            assign pulse = (cnt == CW'(PERIOD - 1));

            assert_period_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
                pulse |=> !pulse);
        end
    endgenerate
endmodule

// File: rtl/cet_swallow.sv
// Three-of-four pulse swallower: when active, withholds every fourth input
// pulse counted from the last reload. Phase advances on every input pulse.
module cet_swallow (
    input  logic clk,
    input  logic rst_n,
    input  logic reload,
    input  logic active,
    input  logic in_en,
    output logic out_en
);
    logic [1:0] phase;

    // Phase counter of input pulses, zeroed on reset or reload.
    always_ff @(posedge clk) begin
        if (!rst_n || reload)
            phase <= 2'd0;
        else if (in_en)
            phase <= phase + 2'd1;
    end

    assign out_en = in_en && !(active && (phase == 2'd3));

    assert_subset_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_en |-> in_en);
    assert_reload_R10: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (phase == 2'd0));
endmodule

// File: rtl/cet_div.sv
// Enable divider: passes one of every (div+1) input pulses. Counter zeroes on
// reload; assumes div only changes together with reload.
module cet_div #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         reload,
    input  logic         in_en,
    input  logic [W-1:0] div,
    output logic         out_en
);
    logic [W-1:0] cnt;

    // Pulse counter, wrapping when it reaches div.
    always_ff @(posedge clk) begin
        if (!rst_n || reload)
            cnt <= '0;
        else if (in_en)
            cnt <= (cnt == div) ? '0 : cnt + 1'b1;
    end

    assign out_en = in_en && (cnt == div);

    assert_cnt_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= div);
    assert_reload_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (cnt == '0));
endmodule

// File: rtl/clk_enable_tree.sv
// Clock-enable divider tree: main source -> optional 3/4 drop -> CPU divider
// -> bus divider -> fixed halving. Also a second source with an off switch.
// Assumes all domains run on clk and qualify their logic with the enables.
module clk_enable_tree
    import cet_pkg::*;
#(
    parameter int                ADDR_W      = 12,
    parameter logic [ADDR_W-1:0] CTRL_OFFSET = 12'h008,
    parameter logic [ADDR_W-1:0] WINDOW_END  = 12'h070,
    parameter int                MAIN_PERIOD = 1,
    parameter int                AUX_PERIOD  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              main_en,
    output logic              aux_en,
    output logic              cpu_en,
    output logic              bus_en,
    output logic              periph_en
);
    cfg_t cfg;
    logic reload;
    logic main_pll, aux_pll, scaled_en;

    cet_ctrl_reg #(.ADDR_W(ADDR_W), .CTRL_OFFSET(CTRL_OFFSET), .WINDOW_END(WINDOW_END)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg(cfg), .reload(reload));

    cet_pulse_src #(.PERIOD(MAIN_PERIOD)) u_main_src (.clk(clk), .rst_n(rst_n), .pulse(main_pll));
    cet_pulse_src #(.PERIOD(AUX_PERIOD))  u_aux_src  (.clk(clk), .rst_n(rst_n), .pulse(aux_pll));

    assign main_en = cfg.bypass ? ref_tick : main_pll;
    assign aux_en  = aux_pll && !cfg.aux_off;

    cet_swallow u_swallow (
        .clk(clk), .rst_n(rst_n), .reload(reload), .active(cfg.three_q),
        .in_en(main_en), .out_en(scaled_en));

    cet_div #(.W(DIV_W)) u_cpu_div (
        .clk(clk), .rst_n(rst_n), .reload(reload), .in_en(scaled_en),
        .div(cfg.cpu_div), .out_en(cpu_en));

    cet_div #(.W(DIV_W)) u_bus_div (
        .clk(clk), .rst_n(rst_n), .reload(reload), .in_en(cpu_en),
        .div(cfg.bus_div), .out_en(bus_en));

    cet_div #(.W(1)) u_periph_div (
        .clk(clk), .rst_n(rst_n), .reload(reload), .in_en(bus_en),
        .div(1'b1), .out_en(periph_en));

    assert_cpu_in_main_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_en |-> main_en);
    assert_bus_in_cpu_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_en |-> cpu_en);
    assert_periph_in_bus_R7: assert property (@(posedge clk) disable iff (!rst_n)
        periph_en |-> bus_en);
    assert_aux_pll_R3: assert property (@(posedge clk) disable iff (!rst_n)
        aux_en |-> aux_pll);
endmodule

// File: tb/clk_enable_tree_test.sv
module clk_enable_tree_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = 12'h000;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        main_en, aux_en, cpu_en, bus_en, periph_en;

    int checks = 0, fails = 0, rc = 0;
    bit done = 0;
    int n_main, n_aux, n_cpu, n_bus, n_per, n_ref, n_nest, first_cpu;
    logic [7:0] cpu_pat;

    always #2 clk = ~clk;

    clk_enable_tree uut (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .main_en(main_en), .aux_en(aux_en), .cpu_en(cpu_en),
        .bus_en(bus_en), .periph_en(periph_en));

    // Reference tick: one cycle in three, changed just after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            rc = (rc == 2) ? 0 : rc + 1;
            ref_tick = (rc == 0);
        end
    end

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 12'h000;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // Count pulses per output over w cycles, starting at the current negedge.
    task automatic window(input int w);
        n_main = 0; n_aux = 0; n_cpu = 0; n_bus = 0; n_per = 0;
        n_ref = 0; n_nest = 0; first_cpu = -1; cpu_pat = '0;
        for (int i = 0; i < w; i++) begin
            n_main += main_en; n_aux += aux_en; n_cpu += cpu_en;
            n_bus += bus_en; n_per += periph_en; n_ref += ref_tick;
            if ((periph_en && !bus_en) || (bus_en && !cpu_en) || (cpu_en && !main_en))
                n_nest++;
            if (cpu_en && first_cpu < 0) first_cpu = i;
            if (i < 8) cpu_pat[i] = cpu_en;
            @(negedge clk);
        end
    endtask

    function automatic logic [31:0] mkword(int c, int b, int q, int byp, int off);
        logic [31:0] w = 32'h0;
        w[31:30] = 2'(c); w[29:28] = 2'(b);
        w[22] = 1'(byp); w[23] = 1'(off); w[14] = 1'(q);
        return w;
    endfunction

    initial begin
        logic [31:0] d;
        int m, s, ec, eb;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset word and 4:2:1 rates from a zeroed start
        window(960);
        check("R1 cpu count", n_cpu, 240);
        check("R1 bus count", n_bus, 120);
        check("R1 periph count", n_per, 60);
        rd(12'h008, d);
        check("R1 reset word", d, 32'hD000_0000);

        // R2..R8: sweep divide fields, quarter select, bypass, second-source off
        for (int k = 0; k < 64; k++) begin
            int c = k % 4, b = (k / 4) % 4, q = (k / 16) % 2, byp = k / 32;
            int off = (k % 2) ^ byp ^ ((k / 4) % 2);
            wr(12'h008, mkword(c, b, q, byp, off));
            window(960);
            m = byp ? n_ref : 960;
            s = q ? (m - m / 4) : m;
            ec = s / (c + 1);
            eb = ec / (b + 1);
            check("R2 main count", n_main, m);
            check("R3 aux count", n_aux, off ? 0 : 480);
            check(q ? "R4/R5 cpu count" : "R5 cpu count", n_cpu, ec);
            check("R6 bus count", n_bus, eb);
            check("R7 periph count", n_per, eb / 2);
            check("R8 nesting violations", n_nest, 0);
        end

        // R4: drop pattern with divide 1
        wr(12'h008, mkword(0, 0, 1, 0, 0));
        window(8);
        check("R4 pulse pattern", cpu_pat, 8'b0111_0111);

        // R10: rewrite mid-count restarts the divider
        wr(12'h008, mkword(2, 0, 0, 0, 0));
        @(negedge clk);
        wr(12'h008, mkword(2, 0, 0, 0, 0));
        window(12);
        check("R10 first cpu pulse index", first_cpu, 2);

        // R9: register access rules
        wr(12'h008, 32'h5000_4000);
        rd(12'h008, d);  check("R9 readback", d, 32'h5000_4000);
        wr(12'h010, 32'hFFFF_FFFF);
        rd(12'h010, d);  check("R9 other word reads zero", d, 0);
        rd(12'h008, d);  check("R9 other word write ignored", d, 32'h5000_4000);
        wr(12'h070, 32'h1234_5678);
        rd(12'h070, d);  check("R9 out-of-window reads zero", d, 0);
        rd(12'h008, d);  check("R9 out-of-window write ignored", d, 32'h5000_4000);
        wr(12'h00A, 32'hAAAA_AAAA);
        rd(12'h00A, d);  check("R9 unaligned reads zero", d, 0);
        rd(12'h008, d);  check("R9 unaligned write ignored", d, 32'h5000_4000);
        wr(12'h088, 32'h0);
        rd(12'h008, d);  check("R9 aliased write ignored", d, 32'h5000_4000);

        finish_run();
    end
endmodule